// File: doc/BRIEF.md
# Memory-to-Memory Byte Copy Sequencer

This block moves a run of bytes from one memory region to another over a single shared memory port. Two address channels are loaded when a copy starts. The first channel walks the source region. The second walks the destination region and also carries the byte count that ends the copy.

Each byte costs two bus cycles. In the first cycle the block strobes a read at the source address and captures the returned byte into an internal 8-bit holding register. In the second cycle it strobes a write at the destination address and drives the held byte. Each address channel steps by one after every byte, either upward or downward. The direction is chosen per channel when the copy starts.

A host pulses `start` with both addresses, both directions and the byte count. It then waits for the one-clock `done` pulse. `busy` is high for exactly the cycles in which the block owns the memory port.

Top module: `mem_copy_seq`

## Requirements
- R1: After a synchronous reset the block is idle: `busy`, `done`, `mem_rd` and `mem_wr` are all 0.
- R2: In every read cycle `mem_rd` is 1, `mem_wr` is 0, and `mem_addr` equals the current source address. The first read of a copy uses the loaded source address.
- R3: In every write cycle `mem_wr` is 1, `mem_addr` equals the current destination address, and `wr_data` equals the byte that `rd_data` carried in the read cycle just before.
- R4: `mem_rd` and `mem_wr` are never 1 together, and every write cycle directly follows a read cycle.
- R5: After each byte the source address moves by one. A `src_down` of 0 moves it up and a `src_down` of 1 moves it down. The direction is sampled with `start`.
- R6: After each byte the destination address moves by one, in the direction given by `dst_down` (0 up, 1 down). It is independent of the source direction.
- R7: A copy started with a `byte_count` N greater than 0 makes exactly N reads and N writes, and `busy` stays high for exactly 2N cycles.
- R8: On completion `done` is 1 for exactly one clock. `busy` falls on the same edge that raises `done`.
- R9: A `start` with `byte_count` 0 makes no memory cycle, leaves `busy` at 0, and gives a single `done` pulse in the next cycle.
- R10: A `start` that arrives while `busy` is 1 is ignored. The running copy keeps its addresses and its count.
- R11: The addresses wrap modulo 2^AW. Stepping up from the all-ones address gives 0, and stepping down from 0 gives all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a copy; sampled only when idle |
| src_addr | input | AW | First source address |
| src_down | input | 1 | Source direction: 0 up, 1 down |
| dst_addr | input | AW | First destination address |
| dst_down | input | 1 | Destination direction: 0 up, 1 down |
| byte_count | input | CW | Number of bytes to copy |
| busy | output | 1 | High while the copy owns the memory port |
| done | output | 1 | One-clock completion pulse |
| mem_addr | output | AW | Memory address for the current cycle |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| rd_data | input | 8 | Byte returned by memory in a read cycle |
| wr_data | output | 8 | Byte driven in a write cycle |

## Verification
Suppose an address channel steps the wrong way, or skips a step. Then the very next read or write cycle presents an address that differs from the expected walk. The bench checks every strobe address in the cycle it appears.

A fault in the holding register shows on `wr_data` in the write cycle right after the faulty read. It then shows again as a wrong byte in the destination region once the copy ends.

A miscounted remainder shows in two ways when the copy finishes. The `done` pulse comes early or late against the 2N-cycle `busy` window, and the read and write totals no longer match N. Wraparound and zero-length copies are exercised on their own, because they touch only edge values of the counters.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } seq_state_e;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } step_dir_e;

    // Per-cycle controls handed from the sequencer to the datapath
    typedef struct packed {
        logic rd;       // read strobe
        logic wr;       // write strobe
        logic sel_dst;  // address mux: 1 selects destination channel
        logic capture;  // load holding register from read data
        logic step;     // advance both address channels
    } bus_ctl_t;

    localparam int NUM_CHAN = 2;
    localparam int CH_SRC   = 0;
    localparam int CH_DST   = 1;

    function automatic bus_ctl_t decode_ctl(seq_state_e st);
        bus_ctl_t c;
        c.rd      = (st == ST_READ);
        c.capture = (st == ST_READ);
        c.wr      = (st == ST_WRITE);
        c.sel_dst = (st == ST_WRITE);
        c.step    = (st == ST_WRITE);
        return c;
    endfunction

endpackage

// File: rtl/mcs_addr_ctr.sv
module mcs_addr_ctr
    import mcs_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  step_dir_e     load_dir,
    input  logic          step,
    output logic [AW-1:0] q
);

    step_dir_e dir_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q     <= '0;
            dir_q <= DIR_UP;
        end else if (load) begin
            q     <= load_val;
            dir_q <= load_dir;
        end else if (step) begin
            if (dir_q == DIR_DOWN) q <= q - 1'b1;
            else                   q <= q + 1'b1;
        end
    end

    // R5 / R6 / R11: one step per byte, modulo 2^AW, in the loaded direction
    assert_step_one_R5: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> (q == AW'($past(dir_q) == DIR_DOWN ? $past(q) - 1'b1
                                                                : $past(q) + 1'b1)));

    assert_hold_idle_R10: assert property (@(posedge clk) disable iff (rst)
        (!step && !load) |=> $stable(q));

endmodule

// File: rtl/mcs_seq_fsm.sv
module mcs_seq_fsm
    import mcs_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [CW-1:0] count_i,
    output seq_state_e    state,
    output bus_ctl_t      ctl,
    output logic          load,
    output logic          done
);

    logic [CW-1:0] remain;
    logic          last_byte;

    assign last_byte = (remain == CW'(1));
    assign load      = (state == ST_IDLE) && start;
    assign ctl       = decode_ctl(state);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            remain <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (count_i == '0) begin
                            done <= 1'b1;
                        end else begin
                            remain <= count_i;
                            state  <= ST_READ;
                        end
                    end
                end
                ST_READ: state <= ST_WRITE;
                ST_WRITE: begin
                    remain <= remain - 1'b1;
                    if (last_byte) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end else begin
                        state <= ST_READ;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R7: remainder drops by exactly one per write cycle
    assert_count_dec_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WRITE) |=> (remain == CW'($past(remain) - 1'b1)));

    assert_active_nonzero_R7: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |-> (remain != '0));

    // R8: done is a single-clock pulse
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R4: a write cycle is always entered from a read cycle
    assert_write_after_read_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WRITE) |-> ($past(state) == ST_READ));

endmodule

// File: rtl/mem_copy_seq.sv
module mem_copy_seq
    import mcs_pkg::*;
#(
    parameter int AW = 12,
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] src_addr,
    input  logic          src_down,
    input  logic [AW-1:0] dst_addr,
    input  logic          dst_down,
    input  logic [CW-1:0] byte_count,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    input  logic [7:0]    rd_data,
    output logic [7:0]    wr_data
);

    localparam int DW = 8;

    seq_state_e    state;
    bus_ctl_t      ctl;
    logic          load;
    logic [DW-1:0] hold_q;
    logic [AW-1:0] ch_addr [NUM_CHAN];

    mcs_seq_fsm #(.CW(CW)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .count_i (byte_count),
        .state   (state),
        .ctl     (ctl),
        .load    (load),
        .done    (done)
    );

    for (genvar ch = 0; ch < NUM_CHAN; ch++) begin : g_chan
        mcs_addr_ctr #(.AW(AW)) u_ctr (
            .clk      (clk),
            .rst      (rst),
            .load     (load),
            .load_val ((ch == CH_SRC) ? src_addr : dst_addr),
            .load_dir (step_dir_e'((ch == CH_SRC) ? src_down : dst_down)),
            .step     (ctl.step),
            .q        (ch_addr[ch])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)              hold_q <= '0;
        else if (ctl.capture) hold_q <= rd_data;
    end

    assign mem_addr = ctl.sel_dst ? ch_addr[CH_DST] : ch_addr[CH_SRC];
    assign mem_rd   = ctl.rd;
    assign mem_wr   = ctl.wr;
    assign wr_data  = hold_q;
    assign busy     = (state != ST_IDLE);

    // R4: strobes never overlap
    assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    // R3: written byte is the one read in the previous cycle
    assert_wdata_R3: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> (wr_data == $past(rd_data)));

    // R8: busy is already low when done shows
    assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R9: a zero-length start never claims the bus
    assert_zero_len_R9: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && byte_count == '0) |=> !busy);

endmodule

// File: tb/sim_mem_copy_seq.sv
`timescale 1ns/1ps
module sim_mem_copy_seq;

    localparam int AW = 12;
    localparam int CW = 12;
    localparam int MSZ = 1 << AW;

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic [AW-1:0] src_addr, dst_addr;
    logic          src_down, dst_down;
    logic [CW-1:0] byte_count;
    logic          busy, done, mem_rd, mem_wr;
    logic [AW-1:0] mem_addr;
    logic [7:0]    rd_data, wr_data;

    logic [7:0] mem  [MSZ];
    logic [7:0] snap [MSZ];

    int n_checks = 0;
    int n_errs   = 0;

    // monitor state
    int busy_cyc, done_cnt, rd_cnt, wr_cnt, overlap, addr_err, data_err, seq_err;
    logic [AW-1:0] exp_src, exp_dst;
    logic          exp_sdn, exp_ddn;
    logic [7:0]    last_rd;
    logic          prev_rd;

    always #2 clk = ~clk;

    mem_copy_seq #(.AW(AW), .CW(CW)) u0 (
        .clk(clk), .rst(rst), .start(start),
        .src_addr(src_addr), .src_down(src_down),
        .dst_addr(dst_addr), .dst_down(dst_down),
        .byte_count(byte_count), .busy(busy), .done(done),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .rd_data(rd_data), .wr_data(wr_data)
    );

    assign rd_data = mem[mem_addr];

    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr] <= wr_data;
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (busy)  busy_cyc++;
            if (done)  done_cnt++;
            if (mem_rd && mem_wr) overlap++;
            if (mem_wr && !prev_rd) seq_err++;
            if (mem_rd) begin
                rd_cnt++;
                if (mem_addr != exp_src) addr_err++;
                last_rd = rd_data;
                exp_src = exp_sdn ? exp_src - 1'b1 : exp_src + 1'b1;
            end
            if (mem_wr) begin
                wr_cnt++;
                if (mem_addr != exp_dst) addr_err++;
                if (wr_data != last_rd) data_err++;
                exp_dst = exp_ddn ? exp_dst - 1'b1 : exp_dst + 1'b1;
            end
            prev_rd = mem_rd;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clr_mon();
        busy_cyc = 0; done_cnt = 0; rd_cnt = 0; wr_cnt = 0;
        overlap = 0; addr_err = 0; data_err = 0; seq_err = 0; prev_rd = 1'b0;
    endtask

    task automatic fill_mem(input int seed);
        for (int i = 0; i < MSZ; i++) begin
            mem[i]  = 8'((i * 37 + seed * 11 + (i >> 5)) & 8'hFF);
            snap[i] = mem[i];
        end
    endtask

    task automatic wait_done(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 20000 && !seen; i++) begin
            @(negedge clk);
            if (done) seen = 1'b1;
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; start = 1'b0;
        src_addr = '0; dst_addr = '0; src_down = 1'b0; dst_down = 1'b0; byte_count = '0;
        repeat (3) @(negedge clk);
        chk(!busy && !done, "R1 busy/done after reset", {busy, done}, 0);
        chk(!mem_rd && !mem_wr, "R1 strobes after reset", {mem_rd, mem_wr}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !mem_rd && !mem_wr, "R1 idle after release", {busy, mem_rd, mem_wr}, 0);
    endtask

    // one copy; optional stray start mid-run
    task automatic t_copy(input int s, input int d, input int n, input bit sdn,
                          input bit ddn, input bit stray, input string tag);
        bit seen;
        int bad;
        fill_mem(s + d + n);
        clr_mon();
        exp_src = AW'(s); exp_dst = AW'(d); exp_sdn = sdn; exp_ddn = ddn;
        src_addr = AW'(s); dst_addr = AW'(d); src_down = sdn; dst_down = ddn;
        byte_count = CW'(n); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (stray) begin
            repeat (3) @(negedge clk);
            src_addr = AW'(s + 100); dst_addr = AW'(d + 100); byte_count = CW'(1);
            src_down = ~sdn; dst_down = ~ddn; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait_done(seen);
        chk(seen, {tag, " R8 done seen"}, seen, 1);
        chk(!busy, {tag, " R8 busy low with done"}, busy, 0);
        @(negedge clk);
        chk(!done, {tag, " R8 done one clock"}, done, 0);
        chk(done_cnt == 1, {tag, " R8 done count"}, done_cnt, 1);
        chk(busy_cyc == 2 * n, {tag, " R7 busy cycles"}, busy_cyc, 2 * n);
        chk(rd_cnt == n && wr_cnt == n, {tag, " R7 read/write totals"}, rd_cnt + wr_cnt, 2 * n);
        chk(overlap == 0, {tag, " R4 strobe overlap"}, overlap, 0);
        chk(seq_err == 0, {tag, " R4 write without prior read"}, seq_err, 0);
        chk(addr_err == 0, {tag, " R2 R5 R6 address walk"}, addr_err, 0);
        chk(data_err == 0, {tag, " R3 write data"}, data_err, 0);
        bad = 0;
        for (int i = 0; i < n; i++) begin
            int sa, da;
            sa = sdn ? s - i : s + i;
            da = ddn ? d - i : d + i;
            if (mem[da & (MSZ - 1)] != snap[sa & (MSZ - 1)]) bad++;
        end
        chk(bad == 0, {tag, " R3 destination contents"}, bad, 0);
        if (stray) chk(mem[(d + 100) & (MSZ - 1)] == snap[(d + 100) & (MSZ - 1)],
                       {tag, " R10 stray start wrote nothing"}, 0, 0);
    endtask

    task automatic t_zero();
        fill_mem(5);
        clr_mon();
        src_addr = AW'(10); dst_addr = AW'(20); byte_count = '0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done && !busy, "R9 done next cycle", {done, busy}, 2);
        @(negedge clk);
        chk(!done, "R9 single done", done, 0);
        chk(rd_cnt == 0 && wr_cnt == 0 && busy_cyc == 0, "R9 no memory cycles",
            rd_cnt + wr_cnt + busy_cyc, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_errs++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        t_reset();
        t_copy(16'h100, 16'h400, 8, 1'b0, 1'b0, 1'b0, "up/up");
        t_copy(16'h2F0, 16'h900, 6, 1'b1, 1'b0, 1'b0, "R5 src down");
        t_copy(16'h120, 16'hA40, 5, 1'b0, 1'b1, 1'b0, "R6 dst down");
        t_copy(16'h300, 16'h700, 1, 1'b0, 1'b0, 1'b0, "R7 single byte");
        t_copy(16'hFFE, 16'h800, 4, 1'b0, 1'b0, 1'b0, "R11 src wrap up");
        t_copy(16'h500, 16'h001, 4, 1'b0, 1'b1, 1'b0, "R11 dst wrap down");
        t_copy(16'h200, 16'h600, 10, 1'b0, 1'b0, 1'b1, "R10 stray start");
        t_zero();
        t_copy(16'h040, 16'hC00, 64, 1'b1, 1'b1, 1'b0, "down/down long");
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

endmodule